// File: doc/BRIEF.md
# Configuration Memory Scrub Sequencer

This block periodically repairs radiation-induced bit flips in the configuration memory of a programmable device by rewriting configuration frames from a golden image kept in external nonvolatile storage. Each pass is started by a request and runs a fixed sequence on a simple register port. First it reads the device status register and checks the selected bits. It then reads the control register and compares the whole word. Next it writes a frame address base and reads it back, and continues only if the readback equals the value written. Last, it walks every frame index in ascending order and rewrites each frame that is not masked.

Frames that hold user-writable storage, such as LUT-based RAM or shift registers, are excluded by a per-frame mask, because rewriting them would destroy live user data. A failed register check aborts the pass and records which step failed. Rewriting again only a few cycles after a pass disturbs user logic, so the block enforces a programmable idle interval after every pass, whether it ended normally or was aborted. A zero interval setting selects a parameter default sized for about 0.1 s of controller clock.

Top module: `scrub_sequencer`

## Requirements
- R1: A pass issues its register accesses in this order: a read with select 0 (status), a read with select 1 (control), a write then a read with select 2 (frame address), and then the frame rewrites. A read is complete when `cfg_rvalid_i` returns its data.
- R2: The status check passes when `(cfg_rdata_i & stat_mask_i) == stat_expect_i`, so status bits outside the mask have no effect. A mismatch ends the pass right after the status read with error code 1.
- R3: The control readback must equal `ctrl_expect_i` on all 32 bits. Otherwise the pass ends right after the control read with error code 2.
- R4: The frame-address check writes `far_base_i`, captured when the start is accepted, and reads it back. A differing readback ends the pass with error code 3, and nothing is written to select 3.
- R5: For each frame f in ascending order whose `frame_mask_i[f]` is 0, the block writes `far_base_i + f` with select 2. It then makes FRAME_WORDS writes with select 3, where word w carries the golden word returned for frame f, word w. A frame whose mask bit is 1 produces no access at all.
- R6: On an abort, `err_o` goes high and stays high until reset, even through later good passes. `err_code_o` shows the most recent failing step. No done pulse is given and the pass counter does not change.
- R7: A start is accepted only while the block is idle and the interval has run out. With `start_i` held high from the first idle cycle, `busy_o` stays low for exactly G+1 cycles. G is `gap_len_i` as sampled in the pass's last cycle, or DEF_GAP when that value is 0. This holds after both good and aborted passes.
- R8: `busy_o` rises in the cycle after an accepted start and falls after the last access of the pass. A good pass ends with a one-cycle `done_o` pulse while `busy_o` is low.
- R9: `pass_count_o` counts good passes and saturates at 2^PCNT_W-1.
- R10: Once `cfg_valid_o` is high, it stays high with unchanged `cfg_write_o`, `cfg_sel_o` and `cfg_wdata_o` until a cycle with `cfg_ready_i` high.
- R11: After reset, `busy_o`, `done_o`, `err_o`, `err_code_o`, `pass_count_o`, `cfg_valid_o` and `gold_req_o` are 0. A start in the first cycle after reset is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a scrub pass |
| gap_len_i | input | GAP_W | Idle interval in cycles after a pass; 0 selects DEF_GAP |
| frame_mask_i | input | NUM_FRAMES | 1 = skip this frame (user-writable memory) |
| far_base_i | input | 32 | Frame address base for the pass |
| stat_mask_i | input | 32 | Status bits that take part in the check |
| stat_expect_i | input | 32 | Expected value of the masked status bits |
| ctrl_expect_i | input | 32 | Expected control register value |
| cfg_valid_o | output | 1 | Register access request |
| cfg_ready_i | input | 1 | Request accepted this cycle |
| cfg_write_o | output | 1 | 1 = write, 0 = read |
| cfg_sel_o | output | 2 | 0 status, 1 control, 2 frame address, 3 frame data |
| cfg_wdata_o | output | 32 | Write data |
| cfg_rvalid_i | input | 1 | Read data valid |
| cfg_rdata_i | input | 32 | Read data |
| gold_req_o | output | 1 | Golden word request, held until served |
| gold_frame_o | output | FIDX_W | Frame index of the requested word |
| gold_word_o | output | WIDX_W | Word index within the frame |
| gold_valid_i | input | 1 | Golden word present |
| gold_data_i | input | 32 | Golden word |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle pulse after a good pass |
| err_o | output | 1 | Sticky error flag |
| err_code_o | output | 2 | Last failing step: 1 status, 2 control, 3 frame address |
| pass_count_o | output | PCNT_W | Saturating count of good passes |

## Verification
The start request and the expiry of the idle interval can fall in the same cycle. The bench raises `start_i` in the first idle cycle after each pass and holds it through the whole interval, so the request is present in the exact cycle the timer reaches zero. The test is judged by counting the low cycles of `busy_o` against G+1, after good and after aborted passes, and for both an explicit and the default interval. A second coincidence, the done pulse in the cycle the pass counter saturates, is reached by running more good passes than the counter can hold and comparing the count after each one.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

    typedef enum logic [3:0] {
        S_IDLE     = 4'd0,
        S_STAT_RD  = 4'd1,
        S_STAT_WT  = 4'd2,
        S_CTRL_RD  = 4'd3,
        S_CTRL_WT  = 4'd4,
        S_ADDR_WR  = 4'd5,
        S_ADDR_RD  = 4'd6,
        S_ADDR_WT  = 4'd7,
        S_FRM_PICK = 4'd8,
        S_FRM_ADDR = 4'd9,
        S_GOLD     = 4'd10,
        S_DATA_WR  = 4'd11
    } scrub_state_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_STATUS  = 2'd1,
        ERR_CONTROL = 2'd2,
        ERR_ADDR    = 2'd3
    } scrub_err_e;

    localparam logic [1:0] SEL_STATUS  = 2'd0;
    localparam logic [1:0] SEL_CONTROL = 2'd1;
    localparam logic [1:0] SEL_FADDR   = 2'd2;
    localparam logic [1:0] SEL_FDATA   = 2'd3;

endpackage

// File: rtl/scrub_gap_timer.sv
module scrub_gap_timer #(
    parameter int GAP_W   = 18,
    parameter int DEF_GAP = 238250
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [GAP_W-1:0] len_i,
    output logic             expired_o
);

    localparam logic [GAP_W-1:0] DEF_LEN = GAP_W'(DEF_GAP);

    logic [GAP_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = (len_i == '0) ? DEF_LEN : len_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    // Interval drains by exactly one per cycle unless reloaded
    assert_gap_countdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !expired_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/scrub_frame_cursor.sv
module scrub_frame_cursor #(
    parameter  int NUM_FRAMES  = 64,
    parameter  int FRAME_WORDS = 41,
    localparam int FIDX_W      = (NUM_FRAMES  > 1) ? $clog2(NUM_FRAMES)  : 1,
    localparam int WIDX_W      = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear_i,
    input  logic                  skip_i,
    input  logic                  adv_i,
    input  logic [NUM_FRAMES-1:0] frame_mask_i,
    output logic [FIDX_W-1:0]     frame_o,
    output logic [WIDX_W-1:0]     word_o,
    output logic                  masked_o,
    output logic                  last_frame_o,
    output logic                  last_word_o
);

    localparam int                MASK_SLOTS = 1 << FIDX_W;
    localparam logic [FIDX_W-1:0] LAST_FRM   = FIDX_W'(NUM_FRAMES - 1);
    localparam logic [WIDX_W-1:0] LAST_WRD   = WIDX_W'(FRAME_WORDS - 1);

    typedef struct packed {
        logic [FIDX_W-1:0] frame;
        logic [WIDX_W-1:0] word;
    } cursor_t;

    cursor_t cur_d, cur_q;
    logic [MASK_SLOTS-1:0] mask_pad;

    // Unused index slots read as masked so they can never be written
    for (genvar g = 0; g < MASK_SLOTS; g++) begin : g_mask
        if (g < NUM_FRAMES) begin : g_real
            assign mask_pad[g] = frame_mask_i[g];
        end else begin : g_pad
            assign mask_pad[g] = 1'b1;
        end
    end

    assign last_frame_o = (cur_q.frame == LAST_FRM);
    assign last_word_o  = (cur_q.word == LAST_WRD);
    assign masked_o     = mask_pad[cur_q.frame];
    assign frame_o      = cur_q.frame;
    assign word_o       = cur_q.word;

    always_comb begin
        cur_d = cur_q;
        if (clear_i) begin
            cur_d = '0;
        end else if (skip_i) begin
            cur_d.word = '0;
            if (!last_frame_o) cur_d.frame = cur_q.frame + 1'b1;
        end else if (adv_i) begin
            if (!last_word_o) begin
                cur_d.word = cur_q.word + 1'b1;
            end else begin
                cur_d.word = '0;
                if (!last_frame_o) cur_d.frame = cur_q.frame + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    assert_word_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.word <= LAST_WRD);

    assert_frame_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.frame <= LAST_FRM);

endmodule

// File: rtl/scrub_sequencer.sv
module scrub_sequencer
    import scrub_pkg::*;
#(
    parameter  int NUM_FRAMES  = 64,
    parameter  int FRAME_WORDS = 41,
    parameter  int GAP_W       = 18,
    parameter  int DEF_GAP     = 238250,
    parameter  int PCNT_W      = 16,
    localparam int FIDX_W      = (NUM_FRAMES  > 1) ? $clog2(NUM_FRAMES)  : 1,
    localparam int WIDX_W      = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [GAP_W-1:0]      gap_len_i,
    input  logic [NUM_FRAMES-1:0] frame_mask_i,
    input  logic [31:0]           far_base_i,
    input  logic [31:0]           stat_mask_i,
    input  logic [31:0]           stat_expect_i,
    input  logic [31:0]           ctrl_expect_i,
    output logic                  cfg_valid_o,
    input  logic                  cfg_ready_i,
    output logic                  cfg_write_o,
    output logic [1:0]            cfg_sel_o,
    output logic [31:0]           cfg_wdata_o,
    input  logic                  cfg_rvalid_i,
    input  logic [31:0]           cfg_rdata_i,
    output logic                  gold_req_o,
    output logic [FIDX_W-1:0]     gold_frame_o,
    output logic [WIDX_W-1:0]     gold_word_o,
    input  logic                  gold_valid_i,
    input  logic [31:0]           gold_data_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  err_o,
    output logic [1:0]            err_code_o,
    output logic [PCNT_W-1:0]     pass_count_o
);

    typedef struct packed {
        scrub_state_e      st;
        logic [31:0]       base;
        logic [31:0]       wd;
        logic              err;
        scrub_err_e        code;
        logic [PCNT_W-1:0] pcnt;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              gap_load, gap_expired;
    logic              cur_clear, cur_skip, cur_adv;
    logic              cur_masked, cur_last_frame, cur_last_word;
    logic [FIDX_W-1:0] cur_frame;
    logic [WIDX_W-1:0] cur_word;

    scrub_gap_timer #(
        .GAP_W  (GAP_W),
        .DEF_GAP(DEF_GAP)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (gap_load),
        .len_i    (gap_len_i),
        .expired_o(gap_expired)
    );

    scrub_frame_cursor #(
        .NUM_FRAMES (NUM_FRAMES),
        .FRAME_WORDS(FRAME_WORDS)
    ) u_cursor (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (cur_clear),
        .skip_i      (cur_skip),
        .adv_i       (cur_adv),
        .frame_mask_i(frame_mask_i),
        .frame_o     (cur_frame),
        .word_o      (cur_word),
        .masked_o    (cur_masked),
        .last_frame_o(cur_last_frame),
        .last_word_o (cur_last_word)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        gap_load   = 1'b0;
        cur_clear  = 1'b0;
        cur_skip   = 1'b0;
        cur_adv    = 1'b0;

        case (ctl_q.st)
            S_IDLE: begin
                if (start_i && gap_expired) begin
                    ctl_d.st   = S_STAT_RD;
                    ctl_d.base = far_base_i;
                    cur_clear  = 1'b1;
                end
            end
            S_STAT_RD: if (cfg_ready_i) ctl_d.st = S_STAT_WT;
            S_STAT_WT: begin
                if (cfg_rvalid_i) begin
                    if ((cfg_rdata_i & stat_mask_i) == stat_expect_i) begin
                        ctl_d.st = S_CTRL_RD;
                    end else begin
                        ctl_d.st   = S_IDLE;
                        ctl_d.err  = 1'b1;
                        ctl_d.code = ERR_STATUS;
                        gap_load   = 1'b1;
                    end
                end
            end
            S_CTRL_RD: if (cfg_ready_i) ctl_d.st = S_CTRL_WT;
            S_CTRL_WT: begin
                if (cfg_rvalid_i) begin
                    if (cfg_rdata_i == ctrl_expect_i) begin
                        ctl_d.st = S_ADDR_WR;
                    end else begin
                        ctl_d.st   = S_IDLE;
                        ctl_d.err  = 1'b1;
                        ctl_d.code = ERR_CONTROL;
                        gap_load   = 1'b1;
                    end
                end
            end
            S_ADDR_WR: if (cfg_ready_i) ctl_d.st = S_ADDR_RD;
            S_ADDR_RD: if (cfg_ready_i) ctl_d.st = S_ADDR_WT;
            S_ADDR_WT: begin
                if (cfg_rvalid_i) begin
                    if (cfg_rdata_i == ctl_q.base) begin
                        ctl_d.st = S_FRM_PICK;
                    end else begin
                        ctl_d.st   = S_IDLE;
                        ctl_d.err  = 1'b1;
                        ctl_d.code = ERR_ADDR;
                        gap_load   = 1'b1;
                    end
                end
            end
            S_FRM_PICK: begin
                if (!cur_masked) begin
                    ctl_d.st = S_FRM_ADDR;
                end else if (cur_last_frame) begin
                    ctl_d.st   = S_IDLE;
                    ctl_d.done = 1'b1;
                    if (!(&ctl_q.pcnt)) ctl_d.pcnt = ctl_q.pcnt + 1'b1;
                    gap_load   = 1'b1;
                end else begin
                    cur_skip = 1'b1;
                end
            end
            S_FRM_ADDR: if (cfg_ready_i) ctl_d.st = S_GOLD;
            S_GOLD: begin
                if (gold_valid_i) begin
                    ctl_d.wd = gold_data_i;
                    ctl_d.st = S_DATA_WR;
                end
            end
            S_DATA_WR: begin
                if (cfg_ready_i) begin
                    cur_adv = 1'b1;
                    if (!cur_last_word) begin
                        ctl_d.st = S_GOLD;
                    end else if (!cur_last_frame) begin
                        ctl_d.st = S_FRM_PICK;
                    end else begin
                        ctl_d.st   = S_IDLE;
                        ctl_d.done = 1'b1;
                        if (!(&ctl_q.pcnt)) ctl_d.pcnt = ctl_q.pcnt + 1'b1;
                        gap_load   = 1'b1;
                    end
                end
            end
            default: ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        cfg_valid_o = 1'b0;
        cfg_write_o = 1'b0;
        cfg_sel_o   = SEL_STATUS;
        cfg_wdata_o = '0;
        case (ctl_q.st)
            S_STAT_RD: cfg_valid_o = 1'b1;
            S_CTRL_RD: begin
                cfg_valid_o = 1'b1;
                cfg_sel_o   = SEL_CONTROL;
            end
            S_ADDR_WR: begin
                cfg_valid_o = 1'b1;
                cfg_write_o = 1'b1;
                cfg_sel_o   = SEL_FADDR;
                cfg_wdata_o = ctl_q.base;
            end
            S_ADDR_RD: begin
                cfg_valid_o = 1'b1;
                cfg_sel_o   = SEL_FADDR;
            end
            S_FRM_ADDR: begin
                cfg_valid_o = 1'b1;
                cfg_write_o = 1'b1;
                cfg_sel_o   = SEL_FADDR;
                cfg_wdata_o = ctl_q.base + 32'(cur_frame);
            end
            S_DATA_WR: begin
                cfg_valid_o = 1'b1;
                cfg_write_o = 1'b1;
                cfg_sel_o   = SEL_FDATA;
                cfg_wdata_o = ctl_q.wd;
            end
            default: ;
        endcase
    end

    assign gold_req_o   = (ctl_q.st == S_GOLD);
    assign gold_frame_o = cur_frame;
    assign gold_word_o  = cur_word;
    assign busy_o       = (ctl_q.st != S_IDLE);
    assign done_o       = ctl_q.done;
    assign err_o        = ctl_q.err;
    assign err_code_o   = ctl_q.code;
    assign pass_count_o = ctl_q.pcnt;

    assert_start_after_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(gap_expired));

    assert_hold_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid_o && !cfg_ready_i) |=> (cfg_valid_o && $stable(cfg_write_o)
                                           && $stable(cfg_sel_o) && $stable(cfg_wdata_o)));

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_no_masked_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid_o && cfg_sel_o == SEL_FDATA) |-> !cur_masked);

    assert_count_saturates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (&pass_count_o) |=> (&pass_count_o));

endmodule

// File: tb/scrub_sequencer_test.sv
module scrub_sequencer_test;

    localparam int CLK_PERIOD = 10;
    localparam int NF   = 8;
    localparam int NW   = 3;
    localparam int GW   = 12;
    localparam int DEFG = 40;
    localparam int PW   = 3;
    localparam int FXW  = 3;
    localparam int WXW  = 2;
    localparam int LOGN = 2048;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [GW-1:0]  gap_len_i = '0;
    logic [NF-1:0]  frame_mask_i = '0;
    logic [31:0]    far_base_i = '0;
    logic [31:0]    stat_mask_i = '0;
    logic [31:0]    stat_expect_i = '0;
    logic [31:0]    ctrl_expect_i = '0;
    logic           cfg_valid_o, cfg_write_o;
    logic [1:0]     cfg_sel_o;
    logic [31:0]    cfg_wdata_o;
    logic           cfg_ready_i, cfg_rvalid_i;
    logic [31:0]    cfg_rdata_i;
    logic           gold_req_o, gold_valid_i;
    logic [FXW-1:0] gold_frame_o;
    logic [WXW-1:0] gold_word_o;
    logic [31:0]    gold_data_i;
    logic           busy_o, done_o, err_o;
    logic [1:0]     err_code_o;
    logic [PW-1:0]  pass_count_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    scrub_sequencer #(
        .NUM_FRAMES(NF), .FRAME_WORDS(NW), .GAP_W(GW), .DEF_GAP(DEFG), .PCNT_W(PW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .gap_len_i(gap_len_i),
        .frame_mask_i(frame_mask_i), .far_base_i(far_base_i),
        .stat_mask_i(stat_mask_i), .stat_expect_i(stat_expect_i),
        .ctrl_expect_i(ctrl_expect_i),
        .cfg_valid_o(cfg_valid_o), .cfg_ready_i(cfg_ready_i), .cfg_write_o(cfg_write_o),
        .cfg_sel_o(cfg_sel_o), .cfg_wdata_o(cfg_wdata_o),
        .cfg_rvalid_i(cfg_rvalid_i), .cfg_rdata_i(cfg_rdata_i),
        .gold_req_o(gold_req_o), .gold_frame_o(gold_frame_o), .gold_word_o(gold_word_o),
        .gold_valid_i(gold_valid_i), .gold_data_i(gold_data_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o),
        .pass_count_o(pass_count_o)
    );

    function automatic logic [31:0] gold_fn(input int f, input int w);
        return {8'hC3, 8'(f), 8'(w), 8'(f * 7 + w * 13)};
    endfunction

    // ---------------- device and golden-store emulation ----------------
    logic [31:0] dev_status = '0, dev_ctrl = '0, far_flip = '0;
    logic [31:0] far_reg, pend_val, rdat;
    logic        rdy, pend, rv, gold_ok;
    logic [1:0]  pend_wait;
    logic [1:0]  lg_sel [0:LOGN-1];
    logic        lg_wr  [0:LOGN-1];
    logic [31:0] lg_dat [0:LOGN-1];
    int          log_n, done_cnt, hs_bad;

    assign cfg_ready_i  = rdy;
    assign cfg_rvalid_i = rv;
    assign cfg_rdata_i  = rdat;
    assign gold_valid_i = gold_req_o && gold_ok;
    assign gold_data_i  = gold_fn(int'(gold_frame_o), int'(gold_word_o));

    always @(posedge clk) begin
        if (!rst_n) begin
            rdy <= 1'b0; pend <= 1'b0; rv <= 1'b0; gold_ok <= 1'b0;
            far_reg <= '0; rdat <= '0; pend_val <= '0; pend_wait <= '0;
            log_n <= 0; done_cnt <= 0;
        end else begin
            rdy     <= ($urandom % 4) != 0;
            gold_ok <= ($urandom % 3) != 0;
            rv      <= 1'b0;
            if (done_o) done_cnt <= done_cnt + 1;
            if (pend) begin
                if (pend_wait == 0) begin
                    rv <= 1'b1; rdat <= pend_val; pend <= 1'b0;
                end else begin
                    pend_wait <= pend_wait - 1'b1;
                end
            end
            if (cfg_valid_o && rdy) begin
                lg_sel[log_n % LOGN] <= cfg_sel_o;
                lg_wr[log_n % LOGN]  <= cfg_write_o;
                lg_dat[log_n % LOGN] <= cfg_write_o ? cfg_wdata_o : 32'h0;
                log_n <= log_n + 1;
                if (cfg_write_o) begin
                    if (cfg_sel_o == 2'd2) far_reg <= cfg_wdata_o;
                end else begin
                    pend      <= 1'b1;
                    pend_wait <= 2'($urandom % 3);
                    case (cfg_sel_o)
                        2'd0:    pend_val <= dev_status;
                        2'd1:    pend_val <= dev_ctrl;
                        2'd2:    pend_val <= far_reg ^ far_flip;
                        default: pend_val <= 32'h0;
                    endcase
                end
            end
        end
    end

    // R10 handshake monitor, sampled away from the clock edge
    logic       pv = 1'b0, pr = 1'b0, pw = 1'b0;
    logic [1:0] ps = '0;
    logic [31:0] pd = '0;
    initial hs_bad = 0;
    always @(negedge clk) begin
        if (rst_n && pv && !pr &&
            !(cfg_valid_o && cfg_write_o == pw && cfg_sel_o == ps && cfg_wdata_o == pd))
            hs_bad = hs_bad + 1;
        pv = cfg_valid_o; pr = cfg_ready_i; pw = cfg_write_o; ps = cfg_sel_o; pd = cfg_wdata_o;
    end

    // ---------------- checking ----------------
    int n_chk = 0, n_fail = 0;
    int exp_pcnt = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_good();
        dev_status    = $urandom;
        stat_mask_i   = $urandom;
        stat_expect_i = dev_status & stat_mask_i;
        dev_ctrl      = $urandom;
        ctrl_expect_i = dev_ctrl;
        far_flip      = '0;
    endtask

    // Expected error code: 0 = good pass
    task automatic run_pass(input logic [NF-1:0] mask, input logic [31:0] base,
                            input logic [GW-1:0] gap, input int ecode, input bit first,
                            input string tag);
        logic [1:0]  es [0:63];
        logic        ew [0:63];
        logic [31:0] ed [0:63];
        int n = 0, s, d0, bad = 0;
        frame_mask_i = mask; far_base_i = base; gap_len_i = gap;
        s = log_n; d0 = done_cnt;
        start_i = 1'b1;
        @(negedge clk);
        if (first) chk(busy_o === 1'b1, "R11", "start accepted right after reset", busy_o, 1);
        while (!busy_o) @(negedge clk);
        start_i = 1'b0;
        while (busy_o) @(negedge clk);
        @(negedge clk);
        es[n] = 2'd0; ew[n] = 1'b0; ed[n] = 0; n++;
        if (ecode != 1) begin es[n] = 2'd1; ew[n] = 1'b0; ed[n] = 0; n++; end
        if (ecode == 0 || ecode == 3) begin
            es[n] = 2'd2; ew[n] = 1'b1; ed[n] = base; n++;
            es[n] = 2'd2; ew[n] = 1'b0; ed[n] = 0; n++;
        end
        if (ecode == 0) begin
            for (int f = 0; f < NF; f++) begin
                if (!mask[f]) begin
                    es[n] = 2'd2; ew[n] = 1'b1; ed[n] = base + 32'(f); n++;
                    for (int w = 0; w < NW; w++) begin
                        es[n] = 2'd3; ew[n] = 1'b1; ed[n] = gold_fn(f, w); n++;
                    end
                end
            end
        end
        chk(log_n - s == n, "R1", {tag, " access count"}, log_n - s, n);
        if (log_n - s == n) begin
            for (int i = 0; i < n; i++) begin
                int k = (s + i) % LOGN;
                if (lg_sel[k] != es[i] || lg_wr[k] != ew[i] || (ew[i] && lg_dat[k] != ed[i]))
                    bad++;
            end
        end
        chk(bad == 0, (ecode == 0) ? "R5" : "R1", {tag, " access sequence mismatches"}, bad, 0);
        if (ecode == 0 && exp_pcnt < (1 << PW) - 1) exp_pcnt++;
        chk(done_cnt - d0 == (ecode == 0 ? 1 : 0), "R8", {tag, " done pulses"},
            done_cnt - d0, ecode == 0 ? 1 : 0);
        chk(int'(pass_count_o) == exp_pcnt, "R9", {tag, " pass count"}, pass_count_o, exp_pcnt);
        if (ecode != 0) begin
            chk(err_o === 1'b1, "R6", {tag, " error flag"}, err_o, 1);
            chk(int'(err_code_o) == ecode,
                (ecode == 1) ? "R2" : (ecode == 2) ? "R3" : "R4",
                {tag, " error code"}, err_code_o, ecode);
        end
    endtask

    // Hold start from the first idle cycle and count idle cycles
    task automatic gap_probe(input logic [GW-1:0] gap, input int exp_idle, input string tag);
        int idle = 1;
        gap_len_i = gap;
        start_i   = 1'b1;
        while (!busy_o) @(negedge clk);
        while (busy_o) @(negedge clk);
        forever begin
            @(negedge clk);
            if (busy_o) break;
            idle++;
        end
        start_i = 1'b0;
        chk(idle == exp_idle, "R7", {tag, " idle cycles before restart"}, idle, exp_idle);
        while (busy_o) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd24681357);
        set_good();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o === 1'b0 && done_o === 1'b0 && cfg_valid_o === 1'b0 && gold_req_o === 1'b0,
            "R11", "idle outputs after reset", {busy_o, done_o, cfg_valid_o, gold_req_o}, 0);
        chk(err_o === 1'b0 && err_code_o === 2'd0 && pass_count_o === '0,
            "R11", "status outputs after reset", {err_o, err_code_o, pass_count_o}, 0);

        // directed: first pass straight after reset
        run_pass(8'b0110_0010, 32'h0040_0100, 12'd5, 0, 1'b1, "first");

        // corner masks
        set_good();
        run_pass('1, 32'h1000_0000, 12'd4, 0, 1'b0, "all-masked");
        set_good();
        run_pass('0, 32'hFFFF_FFFC, 12'd4, 0, 1'b0, "none-masked");

        // random good passes (R2 status bits outside mask vary)
        for (int p = 0; p < 7; p++) begin
            set_good();
            run_pass(NF'($urandom), $urandom, GW'(2 + $urandom % 12), 0, 1'b0, "random");
        end

        // interval with explicit value and default
        set_good();
        frame_mask_i = '1;
        gap_probe(12'd7, 8, "explicit gap");
        gap_probe(12'd0, DEFG + 1, "default gap");

        // failures
        set_good();
        stat_mask_i   = stat_mask_i | 32'h0000_0100;
        stat_expect_i = (dev_status & stat_mask_i) ^ 32'h0000_0100;
        run_pass(8'h0F, 32'h2222_0000, 12'd3, 1, 1'b0, "status mismatch");
        set_good();
        ctrl_expect_i = dev_ctrl ^ 32'h8000_0000;
        run_pass(8'h0F, 32'h3333_0000, 12'd3, 2, 1'b0, "control mismatch");
        set_good();
        far_flip = 32'h0000_0400;
        run_pass(8'h0F, 32'h4444_0000, 12'd3, 3, 1'b0, "address mismatch");

        // interval also follows an aborted pass
        far_flip = 32'h0000_0001;
        gap_probe(12'd9, 10, "gap after abort");
        exp_pcnt = exp_pcnt;

        // good pass after errors: flag stays, code keeps last failure
        set_good();
        run_pass(8'hA5, 32'h5555_0000, 12'd3, 0, 1'b0, "recovery");
        chk(err_o === 1'b1, "R6", "flag held after good pass", err_o, 1);
        chk(err_code_o === 2'd3, "R6", "code held after good pass", err_code_o, 3);

        chk(hs_bad == 0, "R10", "request changed before acceptance", hs_bad, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
            $finish;
        end
    end

endmodule